// File: doc/BRIEF.md
# Read-Enable Emulating RAM Port

This block wraps a small synchronous storage cell that exposes only one combined read-write port. That cell reads on every cycle it is enabled, including every cycle it writes, and it has no clock enable on its read-data register. The wrapper presents separate read and write channels to the user, each with its own enable and address. It steers both channels onto the single physical address input. It then rebuilds the missing read-data clock enable from a holding register and an output multiplexer.

The output multiplexer is driven by a two-state machine. State `SEL_HELD` shows the holding register and state `SEL_FRESH` shows the raw cell output. There are four transitions. `T_ARM` goes from `SEL_HELD` to `SEL_FRESH` on an accepted read. `T_KEEP` stays in `SEL_FRESH` on another read. `T_DROP` goes from `SEL_FRESH` to `SEL_HELD` when no read follows. `T_IDLE` stays in `SEL_HELD` while no read arrives. In `SEL_FRESH` the holding register captures the raw output, so the value stays on the pins once the machine falls back to `SEL_HELD`.

Requests that the single port cannot serve are flagged on `conflict` one cycle later. In such a cycle the write is dropped and the read still proceeds. The parameter `EXCL_MODE` picks the policy. At 0 (shared), a read and a write may share a cycle if they present the same address. At 1 (exclusive), any cycle with both enables set is refused.

Top module: `rden_emul_ram`

## Requirements
- R1: After reset, `rd_data` is 0 and `conflict` is 0. Every storage word reads as 0 until it is written.
- R2: A read requested in cycle t (`rd_en`=1, `rd_addr`=A) shows the contents of word A on `rd_data` during cycle t+1.
- R3: In a cycle following one with `rd_en`=0, `rd_data` repeats its previous value, even when writes have changed the raw cell output.
- R4: In shared mode, a read and a write to the same address in one cycle return the old contents on `rd_data` in the next cycle. The write still takes effect.
- R5: In shared mode, `rd_en`=1 and `wr_en`=1 with `rd_addr`≠`wr_addr` in cycle t raise `conflict` for exactly cycle t+1. The write is discarded and the read of `rd_addr` is served.
- R6: `conflict` is 0 in any cycle that follows a cycle without both enables set. In shared mode it is also 0 after a same-address read-with-write.
- R7: In exclusive mode, any cycle with both enables set raises `conflict` in the next cycle, whether or not the addresses match. The write is discarded and the read is served.
- R8: A write alone stores `wr_data` at `wr_addr`, and a read alone uses `rd_addr`. The two addresses come from independent sources.
- R9: Reads on consecutive cycles each deliver their own word one cycle later, with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read request; acts as clock enable of read data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read data, valid the cycle after a read, held otherwise |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| conflict | output | 1 | One-cycle flag for a refused read-with-write |

## Verification
A read and a write can land in the same cycle. The outcome then depends on the address match and the mode: a read-first return, or a refused write with `conflict` raised. The bench drives a shared-mode and an exclusive-mode instance with identical stimulus. It issues same-address and different-address read-with-write cycles, and writes during held stretches. For each instance, a reference model predicts both the data and the flag. After every dropped write, a follow-up read of the write target confirms that the word kept its old value.

// File: rtl/rden_emul_pkg.sv
package rden_emul_pkg;
    typedef enum logic {
        SEL_HELD  = 1'b0,
        SEL_FRESH = 1'b1
    } rd_sel_e;
endpackage

// File: rtl/rden_emul_cell.sv
// Single-port storage cell: reads on every enabled cycle (read-first),
// no clock enable on its read-data register.
module rden_emul_cell #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (en) begin
            q <= words[addr];
            if (we) words[addr] <= wdata;
        end
    end
endmodule

// File: rtl/rden_emul_merge.sv
// Steers two logical channels onto one physical port and detects clashes.
module rden_emul_merge #(
    parameter int ADDR_W    = 4,
    parameter bit EXCL_MODE = 1'b0
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              phys_en,
    output logic              phys_we,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              clash
);
    logic both;
    assign both = rd_en & wr_en;

    generate
        if (EXCL_MODE) begin : g_excl
            assign clash = both;
        end else begin : g_shared
            assign clash = both & (rd_addr != wr_addr);
        end
    endgenerate

    always_comb begin
        phys_we   = wr_en & ~clash;
        phys_en   = rd_en | phys_we;
        phys_addr = phys_we ? wr_addr : rd_addr;
    end
endmodule

// File: rtl/rden_emul_hold.sv
// Rebuilds a read-data clock enable: select state machine plus hold register.
module rden_emul_hold
    import rden_emul_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_take,
    input  logic [DATA_W-1:0] raw_q,
    output logic [DATA_W-1:0] rd_data
);
    rd_sel_e           state, state_nx;
    logic [DATA_W-1:0] held;

    always_comb begin
        state_nx = state;
        unique case (state)
            SEL_HELD:  state_nx = rd_take ? SEL_FRESH : SEL_HELD;  // T_ARM / T_IDLE
            SEL_FRESH: state_nx = rd_take ? SEL_FRESH : SEL_HELD;  // T_KEEP / T_DROP
            default:   state_nx = SEL_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEL_HELD;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  held <= '0;
        else if (state == SEL_FRESH) held <= raw_q;
    end

    always_comb begin
        rd_data = held;
        unique case (state)
            SEL_HELD:  rd_data = held;
            SEL_FRESH: rd_data = raw_q;
            default:   rd_data = held;
        endcase
    end
endmodule

// File: rtl/rden_emul_ram.sv
module rden_emul_ram #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter bit EXCL_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              conflict
);
    logic              p_en, p_we, clash;
    logic [ADDR_W-1:0] p_addr;
    logic [DATA_W-1:0] raw_q;

    rden_emul_merge #(.ADDR_W(ADDR_W), .EXCL_MODE(EXCL_MODE)) u_merge (
        .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
        .phys_en(p_en), .phys_we(p_we), .phys_addr(p_addr), .clash(clash)
    );

    rden_emul_cell #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cell (
        .clk(clk), .rst_n(rst_n), .en(p_en), .we(p_we),
        .addr(p_addr), .wdata(wr_data), .q(raw_q)
    );

    rden_emul_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .rd_take(rd_en),
        .raw_q(raw_q), .rd_data(rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) conflict <= 1'b0;
        else        conflict <= clash;
    end
endmodule

// File: rtl/rden_emul_ram_chk.sv
module rden_emul_ram_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              conflict
);
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    p_clash_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && rd_addr != wr_addr) |=> conflict);

    p_quiet_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en) |=> !conflict);

    p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> $past(rd_en && wr_en));
endmodule

bind rden_emul_ram rden_emul_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .conflict(conflict)
);

// File: tb/rden_emul_ram_test.sv
module rden_emul_ram_test;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        logic [DW-1:0] data_s;
        logic          flag_s;
        logic [DW-1:0] data_x;
        logic          flag_x;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data_s, rd_data_x;
    logic          conflict_s, conflict_x;

    int vectors = 0;
    int miscompares = 0;
    bit started = 1'b0;

    exp_t          sb[$];
    logic [DW-1:0] mem_s [DEPTH];
    logic [DW-1:0] mem_x [DEPTH];
    logic [DW-1:0] last_s = '0, last_x = '0;

    always #2 clk = ~clk;  // 250 MHz

    rden_emul_ram #(.ADDR_W(AW), .DATA_W(DW), .EXCL_MODE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data_s), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .conflict(conflict_s)
    );

    rden_emul_ram #(.ADDR_W(AW), .DATA_W(DW), .EXCL_MODE(1'b1)) uut_excl (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data_x), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .conflict(conflict_x)
    );

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus at the falling edge and queues
    // what both instances must show after the next rising edge.
    task automatic step(input logic re, input logic [AW-1:0] ra,
                        input logic we, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd, input string tag);
        exp_t e;
        logic cs, cx;
        @(negedge clk);
        rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
        cs = re && we && (ra != wa);
        cx = re && we;
        if (re) begin
            last_s = mem_s[ra];
            last_x = mem_x[ra];
        end
        if (we && !cs) mem_s[wa] = wd;
        if (we && !cx) mem_x[wa] = wd;
        e.data_s = last_s; e.flag_s = cs;
        e.data_x = last_x; e.flag_x = cx;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: samples one time unit after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (started && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "shared rd_data", rd_data_s, e.data_s);
                check(e.tag, "shared conflict", {7'b0, conflict_s}, {7'b0, e.flag_s});
                check(e.tag, "excl rd_data", rd_data_x, e.data_x);
                check(e.tag, "excl conflict", {7'b0, conflict_x}, {7'b0, e.flag_x});
            end
        end
    end

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #100000;
        miscompares++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_s[i] = '0;
            mem_x[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values at the pins
        check("R1", "rd_data after reset", rd_data_s, '0);
        check("R1", "conflict after reset", {7'b0, conflict_s}, 8'h0);
        started = 1'b1;

        step(1, 4'd5, 0, 4'd0, 8'h00, "R1");    // untouched word reads 0
        step(0, 4'd0, 1, 4'd3, 8'hA1, "R8");    // write alone
        step(0, 4'd0, 1, 4'd9, 8'hB2, "R8");
        step(1, 4'd3, 0, 4'd0, 8'h00, "R2");    // read alone
        step(1, 4'd9, 0, 4'd0, 8'h00, "R9");    // back-to-back reads
        step(1, 4'd3, 0, 4'd0, 8'h00, "R9");
        step(0, 4'd0, 1, 4'd3, 8'hC3, "R3");    // write during hold
        step(0, 4'd0, 1, 4'd7, 8'hD4, "R3");
        step(0, 4'd0, 0, 4'd0, 8'h00, "R3");
        step(1, 4'd3, 1, 4'd3, 8'hE5, "R4");    // same address read-with-write
        step(1, 4'd3, 0, 4'd0, 8'h00, "R4");    // new value visible (excl: dropped)
        step(1, 4'd9, 1, 4'd7, 8'h11, "R5");    // clash, different addresses
        step(0, 4'd0, 0, 4'd0, 8'h00, "R6");
        step(1, 4'd7, 0, 4'd0, 8'h00, "R5");    // word 7 kept old value
        step(1, 4'd2, 1, 4'd2, 8'h22, "R7");    // excl flags even same address
        step(1, 4'd2, 0, 4'd0, 8'h00, "R7");
        step(0, 4'd0, 1, 4'd1, 8'h33, "R6");
        step(1, 4'd1, 0, 4'd0, 8'h00, "R8");
        for (int k = 0; k < 24; k++) begin
            step(k[0], 4'(k * 5), k[1], 4'(k * 3), 8'(k * 17 + 9), "R9");
        end
        step(0, 4'd0, 0, 4'd0, 8'h00, "R3");
        step(0, 4'd0, 0, 4'd0, 8'h00, "R6");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule